// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block stands on the processor side of interrupt entry. When a request arrives, the block takes it and marks itself busy. It then waits until the instruction in flight signals completion. After that it counts out an entry sequence whose length depends on four things: the parity of the vector address, the parity of the stack pointer, the width of the data bus and the kind of source. On the last cycle of that sequence it writes the new interrupt priority level and gives a one-cycle pulse that lets the first handler instruction start.

The new priority level depends on the source. A maskable source loads the level it asked for. The watchdog and non-maskable sources force the highest level. Every other source leaves the level as it was. Arbitration between sources, instruction execution and the stacking transfers themselves happen elsewhere.

Top module: `irq_accept_seq`

## Requirements
- R1: While reset is held and after it is released, busy_o is 0, hstart_o is 0 and ipl_o is 0.
- R2: In the idle state, a clock edge that samples req_i high accepts the request. It captures src_i, lvl_i, vec_odd_i, sp_odd_i and bus8_i, and busy_o is 1 from the next cycle on. The source codes are: 0 maskable, 1 watchdog, 2 non-maskable, 3 software, 4 address match, 5 debug, 6 single-step, 7 handled as software.
- R3: After acceptance, the sequence starts only at the edge that samples insn_done_i high. That edge may be the acceptance edge itself. Until then busy_o stays 1 and hstart_o stays 0.
- R4: With bus8_i=0, the base sequence length is 18 cycles, plus 1 if vec_odd_i=1, plus 1 if sp_odd_i=1.
- R5: With bus8_i=1, the base sequence length is 20 cycles, whatever the parity bits are.
- R6: Source code 5 adds 2 cycles to the base. Codes 4 and 6 add 1 cycle. The other codes add none.
- R7: If the sequence starts at edge E and is L cycles long, busy_o is 1 for the L cycles after E. hstart_o is then 1 for exactly one cycle, and busy_o is 0 during that cycle.
- R8: With source code 0, ipl_o takes the captured level when hstart_o rises.
- R9: With source codes 1 or 2, ipl_o becomes 7 when hstart_o rises.
- R10: With source codes 3 to 7, ipl_o does not change.
- R11: ipl_o changes in no cycle other than the cycle in which hstart_o is 1.
- R12: While busy_o is 1, changes on req_i, src_i, lvl_i, vec_odd_i, sp_odd_i and bus8_i do not change the length or the resulting level. An insn_done_i pulse is ignored unless a request is waiting for it.
- R13: If req_i is high in the cycle in which hstart_o is 1, that request is accepted as a new one, and busy_o is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Interrupt request present |
| src_i | input | 3 | Source kind code |
| lvl_i | input | 3 | Requested priority level for maskable sources |
| vec_odd_i | input | 1 | Vector address is odd |
| sp_odd_i | input | 1 | Stack pointer is odd |
| bus8_i | input | 1 | 1 selects the 8-bit data bus, 0 the 16-bit bus |
| insn_done_i | input | 1 | Executing instruction has completed |
| busy_o | output | 1 | Request accepted and entry not yet finished |
| ipl_o | output | 3 | Processor interrupt priority level |
| hstart_o | output | 1 | One-cycle pulse: first handler instruction may start |

## Verification
busy_o rises one cycle after the accepting edge. hstart_o follows exactly L cycles after the edge that samples the completion strobe, where L is the sequence length. ipl_o changes in that same hstart_o cycle. The bench drives all inputs on falling edges and counts the busy cycles between the start edge and the pulse, then compares that count with a length it computes itself. In the pulse cycle it checks the level against a separately kept model. One falling edge later it confirms the pulse has ended and the level holds.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [2:0] {
    SRC_MASKABLE = 3'd0,
    SRC_WATCHDOG = 3'd1,
    SRC_NONMASK  = 3'd2,
    SRC_SOFTWARE = 3'd3,
    SRC_ADDRHIT  = 3'd4,
    SRC_DEBUG    = 3'd5,
    SRC_STEP     = 3'd6,
    SRC_SPARE    = 3'd7
  } irq_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SEQ  = 2'd2
  } seq_state_e;

  // Cycles added on top of the bus/alignment base for a given source.
  function automatic int unsigned src_extra(irq_src_e s);
    case (s)
      SRC_DEBUG:            return 2;
      SRC_ADDRHIT, SRC_STEP: return 1;
      default:              return 0;
    endcase
  endfunction

  // Base entry length before the source-specific addition.
  function automatic int unsigned base_len(logic bus8, logic vodd, logic sodd,
                                           int unsigned b16, int unsigned b8);
    if (bus8) return b8;
    return b16 + int'(vodd) + int'(sodd);
  endfunction

  // Source forces the top level.
  function automatic logic forces_top(irq_src_e s);
    return (s == SRC_WATCHDOG) || (s == SRC_NONMASK);
  endfunction

endpackage

// File: rtl/irq_len_calc.sv
module irq_len_calc
  import irq_accept_pkg::*;
#(
  parameter int BASE16_CYC = 18,
  parameter int BASE8_CYC  = 20,
  parameter int CNT_W      = 5
) (
  input  irq_src_e         src_i,
  input  logic             bus8_i,
  input  logic             vec_odd_i,
  input  logic             sp_odd_i,
  output logic [CNT_W-1:0] len_o
);

  int unsigned total;

  always_comb begin
    total = base_len(bus8_i, vec_odd_i, sp_odd_i, BASE16_CYC, BASE8_CYC)
            + src_extra(src_i);
    len_o = CNT_W'(total);
  end

endmodule

// File: rtl/irq_ipl_rule.sv
module irq_ipl_rule
  import irq_accept_pkg::*;
#(
  parameter int IPL_W = 3
) (
  input  irq_src_e         src_i,
  input  logic [IPL_W-1:0] lvl_i,
  input  logic [IPL_W-1:0] cur_i,
  output logic [IPL_W-1:0] nxt_o
);

  always_comb begin
    if (src_i == SRC_MASKABLE)  nxt_o = lvl_i;
    else if (forces_top(src_i)) nxt_o = '1;
    else                        nxt_o = cur_i;
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_accept_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             idle_o,
  output logic             busy_o,
  output logic             accept_o,
  output logic             seq_start_o,
  output logic             seq_last_o,
  output logic             hstart_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic             hstart_q;

  assign idle_o      = (state_q == ST_IDLE);
  assign busy_o      = !idle_o;
  assign accept_o    = idle_o && req_i;
  assign seq_start_o = (accept_o && done_i) || ((state_q == ST_WAIT) && done_i);
  assign seq_last_o  = (state_q == ST_SEQ) && (cnt_q == CNT_W'(1));
  assign hstart_o    = hstart_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept_o)   state_d = done_i ? ST_SEQ : ST_WAIT;
      ST_WAIT: if (done_i)     state_d = ST_SEQ;
      ST_SEQ:  if (seq_last_o) state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      hstart_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      hstart_q <= seq_last_o;
      if (seq_start_o)           cnt_q <= len_i;
      else if (state_q == ST_SEQ) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_accept_pkg::*;
#(
  parameter int IPL_W      = 3,
  parameter int BASE16_CYC = 18,
  parameter int BASE8_CYC  = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [2:0]       src_i,
  input  logic [IPL_W-1:0] lvl_i,
  input  logic             vec_odd_i,
  input  logic             sp_odd_i,
  input  logic             bus8_i,
  input  logic             insn_done_i,
  output logic             busy_o,
  output logic [IPL_W-1:0] ipl_o,
  output logic             hstart_o
);

  localparam int MAX_EXTRA = 2;
  localparam int B16_MAX   = BASE16_CYC + 2;
  localparam int LEN_MAX   = ((B16_MAX > BASE8_CYC) ? B16_MAX : BASE8_CYC) + MAX_EXTRA;
  localparam int CNT_W     = $clog2(LEN_MAX + 1);

  // Captured request attributes.
  irq_src_e         src_q;
  logic [IPL_W-1:0] lvl_q;
  logic             vodd_q, sodd_q, bus8_q;

  // Named internal events.
  logic             idle_w, accept_w, seq_start_w, seq_last_w;
  logic [CNT_W-1:0] len_w;
  logic [IPL_W-1:0] ipl_q, ipl_nxt_w;

  // Live inputs count in the accepting cycle, captured values afterwards.
  irq_src_e src_sel;
  logic     vodd_sel, sodd_sel, bus8_sel;

  assign src_sel  = idle_w ? irq_src_e'(src_i) : src_q;
  assign vodd_sel = idle_w ? vec_odd_i : vodd_q;
  assign sodd_sel = idle_w ? sp_odd_i  : sodd_q;
  assign bus8_sel = idle_w ? bus8_i    : bus8_q;

  irq_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .done_i      (insn_done_i),
    .len_i       (len_w),
    .idle_o      (idle_w),
    .busy_o      (busy_o),
    .accept_o    (accept_w),
    .seq_start_o (seq_start_w),
    .seq_last_o  (seq_last_w),
    .hstart_o    (hstart_o)
  );

  irq_len_calc #(
    .BASE16_CYC (BASE16_CYC),
    .BASE8_CYC  (BASE8_CYC),
    .CNT_W      (CNT_W)
  ) u_len (
    .src_i     (src_sel),
    .bus8_i    (bus8_sel),
    .vec_odd_i (vodd_sel),
    .sp_odd_i  (sodd_sel),
    .len_o     (len_w)
  );

  irq_ipl_rule #(.IPL_W(IPL_W)) u_ipl (
    .src_i (src_q),
    .lvl_i (lvl_q),
    .cur_i (ipl_q),
    .nxt_o (ipl_nxt_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_MASKABLE;
      lvl_q  <= '0;
      vodd_q <= 1'b0;
      sodd_q <= 1'b0;
      bus8_q <= 1'b0;
      ipl_q  <= '0;
    end else begin
      if (accept_w) begin
        src_q  <= irq_src_e'(src_i);
        lvl_q  <= lvl_i;
        vodd_q <= vec_odd_i;
        sodd_q <= sp_odd_i;
        bus8_q <= bus8_i;
      end
      if (seq_last_w) ipl_q <= ipl_nxt_w;
    end
  end

  assign ipl_o = ipl_q;

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int IPL_W = 3,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             hstart,
  input logic [IPL_W-1:0] ipl,
  input logic             accept,
  input logic             seq_start,
  input logic             seq_last,
  input logic [2:0]       src_q,
  input logic [IPL_W-1:0] lvl_q,
  input logic [CNT_W-1:0] len
);

  logic [7:0]       win_cnt;
  logic [CNT_W-1:0] win_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      win_len <= '0;
    end else if (seq_start) begin
      win_cnt <= 8'd1;
      win_len <= len;
    end else if (win_cnt != 8'hFF) begin
      win_cnt <= win_cnt + 8'd1;
    end
  end

  // R7: the sequence lasts the length fixed at its start
  p_seq_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |-> (win_cnt == 8'(win_len)));

  p_hstart_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hstart |=> !hstart);

  p_hstart_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hstart |-> !busy);

  p_no_accept_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept);

  p_ipl_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hstart |-> $stable(ipl));

  p_ipl_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart && src_q == 3'd0) |-> (ipl == lvl_q));

  p_ipl_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart && (src_q == 3'd1 || src_q == 3'd2)) |-> (ipl == '1));

  p_ipl_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart && src_q >= 3'd3) |-> $stable(ipl));

endmodule

bind irq_accept_seq irq_accept_chk #(.IPL_W(IPL_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy_o),
  .hstart    (hstart_o),
  .ipl       (ipl_o),
  .accept    (accept_w),
  .seq_start (seq_start_w),
  .seq_last  (seq_last_w),
  .src_q     (src_q),
  .lvl_q     (lvl_q),
  .len       (len_w)
);

// File: tb/sim_irq_accept_seq.sv
module sim_irq_accept_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_i = 1'b0;
  logic [2:0] src_i = 3'd0;
  logic [2:0] lvl_i = 3'd0;
  logic       vec_odd_i = 1'b0;
  logic       sp_odd_i = 1'b0;
  logic       bus8_i = 1'b0;
  logic       insn_done_i = 1'b0;
  logic       busy_o;
  logic [2:0] ipl_o;
  logic       hstart_o;

  int tests = 0;
  int fails = 0;
  int exp_ipl = 0;

  always #5 clk = ~clk;

  irq_accept_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .src_i(src_i), .lvl_i(lvl_i),
    .vec_odd_i(vec_odd_i), .sp_odd_i(sp_odd_i), .bus8_i(bus8_i),
    .insn_done_i(insn_done_i), .busy_o(busy_o), .ipl_o(ipl_o), .hstart_o(hstart_o)
  );

  function automatic int want_len(int s, bit vo, bit so, bit b8);
    int n;
    n = b8 ? 20 : (18 + (vo ? 1 : 0) + (so ? 1 : 0));
    if (s == 5) n += 2;
    else if (s == 4 || s == 6) n += 1;
    return n;
  endfunction

  function automatic int want_ipl(int s, int l, int cur);
    if (s == 0) return l;
    if (s == 1 || s == 2) return 7;
    return cur;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count busy cycles after the start edge until hstart_o, then check level.
  task automatic finish_seq(int s, int l, bit vo, bit so, bit b8, bit noise);
    int k = 0;
    int iters = 0;
    while (!hstart_o && iters < 100) begin
      if (busy_o) k++;
      if (noise && k == 3) begin
        req_i = 1'b1; src_i = 3'(s ^ 3); lvl_i = 3'(~l);
        vec_odd_i = ~vo; sp_odd_i = ~so; bus8_i = ~b8; insn_done_i = 1'b1;
      end
      if (noise && k == 4) begin req_i = 1'b0; insn_done_i = 1'b0; end
      iters++;
      @(negedge clk);
    end
    if (b8) check("R5 length 8-bit", k, want_len(s, vo, so, b8));
    else if (s >= 4 && s <= 6) check("R6 length with source extra", k, want_len(s, vo, so, b8));
    else check("R4 length 16-bit", k, want_len(s, vo, so, b8));
    check("R7 busy low at handler start", busy_o, 0);
    exp_ipl = want_ipl(s, l, exp_ipl);
    if (s == 0) check("R8 level loaded", ipl_o, exp_ipl);
    else if (s == 1 || s == 2) check("R9 level forced", ipl_o, exp_ipl);
    else check("R10 level kept", ipl_o, exp_ipl);
  endtask

  task automatic run_irq(int s, int l, bit vo, bit so, bit b8, int wait_n, bit noise);
    @(negedge clk);
    req_i = 1'b1; src_i = 3'(s); lvl_i = 3'(l);
    vec_odd_i = vo; sp_odd_i = so; bus8_i = b8;
    insn_done_i = (wait_n == 0);
    @(negedge clk);
    req_i = 1'b0; insn_done_i = 1'b0;
    check("R2 busy after accept", busy_o, 1);
    if (wait_n > 0) begin
      for (int i = 0; i < wait_n; i++) begin
        check("R3 waits for completion", {busy_o, hstart_o}, 2'b10);
        if (noise) begin
          req_i = 1'b1; src_i = 3'(s + 1); lvl_i = 3'(l + 2);
          vec_odd_i = ~vo; sp_odd_i = ~so; bus8_i = ~b8;
        end
        @(negedge clk);
      end
      req_i = 1'b0; insn_done_i = 1'b1;
      @(negedge clk);
      insn_done_i = 1'b0;
    end
    finish_seq(s, l, vo, so, b8, noise);
    @(negedge clk);
    check("R7 single-cycle pulse", hstart_o, 0);
    check("R11 level holds after pulse", ipl_o, exp_ipl);
  endtask

  initial begin
    #1500000;
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset busy", busy_o, 0);
    check("R1 reset pulse", hstart_o, 0);
    check("R1 reset level", ipl_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {busy_o, hstart_o, ipl_o}, 0);

    // R12: completion strobe with no request does nothing
    insn_done_i = 1'b1;
    @(negedge clk);
    insn_done_i = 1'b0;
    @(negedge clk);
    check("R12 stray completion ignored", busy_o, 0);

    // Directed corners on the 16-bit bus (R4), the 8-bit bus (R5) and source extras (R6)
    run_irq(0, 5, 0, 0, 0, 0, 0);
    run_irq(3, 2, 1, 0, 0, 2, 0);
    run_irq(0, 3, 0, 1, 0, 1, 0);
    run_irq(2, 1, 1, 1, 0, 4, 0);
    run_irq(0, 0, 1, 1, 1, 0, 0);
    run_irq(5, 4, 0, 0, 0, 3, 1);
    run_irq(4, 4, 1, 1, 1, 1, 0);
    run_irq(6, 4, 1, 0, 0, 0, 1);
    run_irq(0, 6, 0, 0, 1, 2, 1);
    run_irq(1, 0, 0, 1, 1, 0, 0);
    run_irq(7, 0, 0, 0, 0, 1, 0);

    // R13: a request held through the pulse is taken as a new one
    @(negedge clk);
    req_i = 1'b1; src_i = 3'd0; lvl_i = 3'd2;
    vec_odd_i = 1'b0; sp_odd_i = 1'b0; bus8_i = 1'b0; insn_done_i = 1'b1;
    @(negedge clk);
    insn_done_i = 1'b0;
    while (!hstart_o && busy_o) @(negedge clk);
    exp_ipl = 2;
    check("R8 level from held request", ipl_o, 2);
    src_i = 3'd2;
    @(negedge clk);
    check("R13 re-accept after pulse", busy_o, 1);
    req_i = 1'b0; insn_done_i = 1'b1;
    @(negedge clk);
    insn_done_i = 1'b0;
    finish_seq(2, 0, 0, 0, 0, 0);
    @(negedge clk);

    // Constrained random mix
    for (int n = 0; n < 60; n++) begin
      int s = int'($urandom_range(0, 7));
      int l = int'($urandom_range(0, 7));
      bit vo = 1'($urandom_range(0, 1));
      bit so = 1'($urandom_range(0, 1));
      bit b8 = 1'($urandom_range(0, 1));
      int w = int'($urandom_range(0, 5));
      bit nz = 1'($urandom_range(0, 1));
      run_irq(s, l, vo, so, b8, w, nz);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule